// File: doc/BRIEF.md
# I2C Command and Register Interface

This block is the serial front end of a segment display and key-scan controller. It is an I2C target that answers to one fixed 7-bit address. It turns the first data byte of each write transfer into either a control command or a register address. It holds the control settings, and it keeps one address pointer that selects the display memory, the three key-data bytes or the interrupt-flag byte. The display memory and the key logic sit outside the block. They see a write strobe and a pointer, and they return read data for the current pointer without a register stage.

SCL and SDA are oversampled on the system clock. Each line passes through a two-stage synchronizer and a stability filter before START, STOP and clock edges are derived from it. The block never stretches the clock.

The transfer state machine has eight states:
- `ST_IDLE`: the bus is free.
- `ST_ADDR`: target address byte being received.
- `ST_ADDR_ACK`: address acknowledged.
- `ST_WR_BYTE`: write byte being received.
- `ST_WR_ACK`: write byte acknowledged.
- `ST_RD_BYTE`: read byte being shifted out.
- `ST_RD_ACK`: waiting for the controller's acknowledge.
- `ST_SKIP`: ignore the bus until the next START or STOP.

The named transitions are:
- START from any state goes to `ST_ADDR`.
- STOP from any state goes to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on an address match, and to `ST_SKIP` otherwise.
- `ST_ADDR_ACK` goes to `ST_RD_BYTE` when the direction bit is 1, and to `ST_WR_BYTE` when it is 0.
- `ST_WR_BYTE` and `ST_WR_ACK` alternate.
- `ST_RD_BYTE` goes to `ST_RD_ACK`.
- `ST_RD_ACK` goes to `ST_RD_BYTE` when the controller acknowledges, and to `ST_SKIP` when it does not.

Top module: `i2c_cmd_regif`

## Requirements
- R1: The block pulls SDA low in the acknowledge slot only when the 7 bits after START equal 1110011 (address byte 0xE6 to write, 0xE7 to read). Any other address gets no acknowledge and changes no setting.
- R2: After reset the block is in standby with the display off, 20x4 mode selected, segment pin function, active-low interrupt polarity, scan period code 0 and pointer 0x00.
- R3: A first byte matching 1000_0ds0 sets the display-on flag from bit 2 (d) and the run flag from bit 1 (s): 1 means run, 0 means standby.
- R4: A first byte matching 1010_0pim sets three fields: the interrupt polarity from bit 2 (p, 1 = active high), the interrupt pin function from bit 1 (i), and 16x8 mode from bit 0 (m).
- R5: A first byte matching 11111ccc loads the 3-bit scan period code ccc.
- R6: A first byte that matches no command and no pointer form leaves the settings and the pointer unchanged. This covers 0010_0011 and any 1xxx_xxxx byte outside R3 to R5.
- R7: After a control command, the remaining bytes of the same transfer are acknowledged but never written.
- R8: A first byte 0000_aaaa sets the pointer to aaaa. Each following byte is written at the pointer, and then the pointer advances. In 20x4 mode the pointer wraps from 0x09 to 0x00.
- R9: In 16x8 mode a write-side advance wraps the pointer from 0x0F to 0x00.
- R10: Read bytes leave MSB first, loaded from the pointer. The pointer advances only when the controller acknowledges, and display reads wrap from 0x0F to 0x00.
- R11: First bytes 0010_00kk (kk 0 to 2) point at key bytes 0x20 to 0x22, and key reads wrap from 0x22 to 0x20. Each key byte loaded pulses `key_rd` once. The flag pointer 0x30 does not advance.
- R12: In standby, every first byte except a system set command is ignored, and no display write occurs.
- R13: A repeated START within a transfer begins a new address phase exactly as a START does.
- R14: A controller NACK ends a read: the block releases SDA, drives no further data and leaves the pointer unadvanced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw serial clock line |
| sda_in | input | 1 | Raw serial data line as seen on the bus |
| sda_pull | output | 1 | 1 drives SDA low (open-drain enable) |
| ptr_addr | output | 8 | Current register pointer, used for writes and reads |
| rd_data | input | 8 | Byte at `ptr_addr`, supplied combinationally |
| wr_en | output | 1 | One-cycle display memory write strobe |
| wr_data | output | 8 | Byte to write at `ptr_addr` |
| key_rd | output | 1 | Pulse when a key-data byte is loaded for reading |
| cfg_normal | output | 1 | 1 = running, 0 = standby |
| cfg_disp_on | output | 1 | Display enable |
| cfg_mode16 | output | 1 | 1 = 16x8 mode, 0 = 20x4 mode |
| cfg_int_pin | output | 1 | Shared pin acts as interrupt output |
| cfg_int_high | output | 1 | Interrupt output active high |
| cfg_scan_per | output | 3 | Key scan period code |

## Verification
The bench builds the block with its default parameters: a filter length of 3 and address 1110011. With these values the filter latency is short enough for a quarter-bit time of 8 clocks. That allows a sweep of every command byte from 0x80 to 0xFF, each checked against an arithmetic model of the settings, within the cycle budget. Because the sweep passes through standby and back, it covers the standby gate. Directed transfers then reach both write wrap points, the display and key read wraps, repeated START, the controller NACK and a foreign address.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_SKIP
    } xfer_state_t;

    typedef enum logic {
        PH_DROP,
        PH_DISP
    } wr_phase_t;

    localparam int          BYTE_W    = 8;
    localparam logic [7:0]  KEY_BASE  = 8'h20;
    localparam logic [7:0]  KEY_LAST  = 8'h22;
    localparam logic [7:0]  FLAG_ADDR = 8'h30;
    localparam logic [3:0]  LAST_20X4 = 4'd9;
endpackage

// File: rtl/i2cr_line_filter.sv
module i2cr_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_cnt;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], din};
        end
    end

    // the output follows only after the synced level differs for FILT_LEN clocks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout    <= 1'b1;
            run_cnt <= '0;
        end else if (synced == dout) begin
            run_cnt <= '0;
        end else if (run_cnt == CW'(FILT_LEN - 1)) begin
            dout    <= synced;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + CW'(1);
        end
    end
endmodule

// File: rtl/i2cr_bus_events.sv
module i2cr_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise  = scl_f & ~scl_q;
    assign scl_fall  = ~scl_f & scl_q;
    assign start_det = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2cr_xfer_fsm.sv
module i2cr_xfer_fsm
    import i2cr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1110011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_f,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              sda_pull,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_first,
    output logic              rd_load,
    output logic              rd_adv
);
    xfer_state_t       state, nxt;
    logic [BYTE_W-1:0] shreg;
    logic [3:0]        bit_cnt;
    logic              first_q;
    logic              acked_q;
    logic              byte_end;

    assign byte_end = scl_fall && (bit_cnt == 4'd8);

    // next state
    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = ST_ADDR;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (byte_end)
                                 nxt = (shreg[7:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (scl_fall) nxt = shreg[0] ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (byte_end) nxt = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) nxt = ST_WR_BYTE;
                ST_RD_BYTE:  if (scl_fall && bit_cnt == 4'd7) nxt = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) nxt = acked_q ? ST_RD_BYTE : ST_SKIP;
                ST_SKIP:     nxt = ST_SKIP;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // shift register, bit counter and per-transfer flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
            first_q <= 1'b0;
            acked_q <= 1'b0;
        end else if (start_det) begin
            bit_cnt <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[BYTE_W-2:0], sda_f};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_end) begin
                        bit_cnt <= '0;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        first_q <= 1'b1;
                        if (shreg[0]) shreg <= rd_byte;
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) first_q <= 1'b0;
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                        bit_cnt <= (bit_cnt == 4'd7) ? 4'd0 : bit_cnt + 4'd1;
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) acked_q <= ~sda_f;
                    if (scl_fall && acked_q) shreg <= rd_byte;
                end
                ST_IDLE, ST_SKIP: begin
                    bit_cnt <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_pull = 1'b0;
        rx_valid = 1'b0;
        rd_load  = 1'b0;
        rd_adv   = 1'b0;
        unique case (state)
            ST_ADDR_ACK: begin
                sda_pull = 1'b1;
                rd_load  = scl_fall && shreg[0];
            end
            ST_WR_BYTE:  rx_valid = byte_end;
            ST_WR_ACK:   sda_pull = 1'b1;
            ST_RD_BYTE:  sda_pull = ~shreg[BYTE_W-1];
            ST_RD_ACK: begin
                rd_adv  = scl_rise && ~sda_f;
                rd_load = scl_fall && acked_q;
            end
            ST_IDLE, ST_ADDR, ST_SKIP: ;
        endcase
        rx_byte  = shreg;
        rx_first = first_q;
    end
endmodule

// File: rtl/i2cr_cmd_regs.sv
module i2cr_cmd_regs
    import i2cr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_first,
    input  logic              rd_adv,
    output logic [7:0]        ptr,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic              normal,
    output logic              disp_on,
    output logic              mode16,
    output logic              int_pin,
    output logic              int_high,
    output logic [2:0]        scan_per
);
    wr_phase_t phase;

    function automatic logic [7:0] wr_step(input logic [7:0] p, input logic m16);
        if (!m16 && p[3:0] == LAST_20X4) return 8'h00;
        return {4'h0, p[3:0] + 4'd1};
    endfunction

    function automatic logic [7:0] rd_step(input logic [7:0] p);
        if (p[7:4] == 4'h0)   return {4'h0, p[3:0] + 4'd1};
        if (p == KEY_LAST)    return KEY_BASE;
        if (p[7:4] == 4'h2)   return p + 8'd1;
        return p;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr      <= 8'h00;
            phase    <= PH_DROP;
            normal   <= 1'b0;
            disp_on  <= 1'b0;
            mode16   <= 1'b0;
            int_pin  <= 1'b0;
            int_high <= 1'b0;
            scan_per <= 3'd0;
        end else if (rx_valid && rx_first) begin
            phase <= PH_DROP;
            if ((rx_byte & 8'hF9) == 8'h80) begin
                disp_on <= rx_byte[2];
                normal  <= rx_byte[1];
            end else if (normal) begin
                if (rx_byte[7:4] == 4'h0) begin
                    ptr   <= {4'h0, rx_byte[3:0]};
                    phase <= PH_DISP;
                end else if (rx_byte[7:2] == 6'b001000 && rx_byte[1:0] != 2'b11) begin
                    ptr <= KEY_BASE | {6'd0, rx_byte[1:0]};
                end else if (rx_byte == FLAG_ADDR) begin
                    ptr <= FLAG_ADDR;
                end else if (rx_byte[7:3] == 5'b10100) begin
                    int_high <= rx_byte[2];
                    int_pin  <= rx_byte[1];
                    mode16   <= rx_byte[0];
                end else if (rx_byte[7:3] == 5'b11111) begin
                    scan_per <= rx_byte[2:0];
                end
            end
        end else if (rx_valid) begin
            if (phase == PH_DISP && normal) ptr <= wr_step(ptr, mode16);
        end else if (rd_adv) begin
            ptr <= rd_step(ptr);
        end
    end

    assign wr_en   = rx_valid && !rx_first && phase == PH_DISP && normal;
    assign wr_data = rx_byte;
endmodule

// File: rtl/i2c_cmd_regif.sv
module i2c_cmd_regif #(
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3,
    parameter logic [6:0] DEV_ADDR    = 7'b1110011
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_pull,
    output logic [7:0] ptr_addr,
    input  logic [7:0] rd_data,
    output logic       wr_en,
    output logic [7:0] wr_data,
    output logic       key_rd,
    output logic       cfg_normal,
    output logic       cfg_disp_on,
    output logic       cfg_mode16,
    output logic       cfg_int_pin,
    output logic       cfg_int_high,
    output logic [2:0] cfg_scan_per
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] line_raw, line_flt;
    logic scl_f, sda_f;
    logic scl_rise, scl_fall, start_det, stop_det;
    logic rx_valid, rx_first, rd_load, rd_adv;
    logic [7:0] rx_byte;

    assign line_raw = {sda_in, scl_in};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        i2cr_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (line_raw[g]),
            .dout (line_flt[g])
        );
    end

    assign scl_f = line_flt[0];
    assign sda_f = line_flt[1];

    i2cr_bus_events u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_f),
        .sda_f    (sda_f),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2cr_xfer_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .sda_f    (sda_f),
        .rd_byte  (rd_data),
        .sda_pull (sda_pull),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .rx_first (rx_first),
        .rd_load  (rd_load),
        .rd_adv   (rd_adv)
    );

    i2cr_cmd_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_valid(rx_valid),
        .rx_byte (rx_byte),
        .rx_first(rx_first),
        .rd_adv  (rd_adv),
        .ptr     (ptr_addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .normal  (cfg_normal),
        .disp_on (cfg_disp_on),
        .mode16  (cfg_mode16),
        .int_pin (cfg_int_pin),
        .int_high(cfg_int_high),
        .scan_per(cfg_scan_per)
    );

    assign key_rd = rd_load && ptr_addr >= i2cr_pkg::KEY_BASE && ptr_addr <= i2cr_pkg::KEY_LAST;
endmodule

// File: rtl/i2cr_checks.sv
module i2cr_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_f,
    input logic       sda_pull,
    input logic       wr_en,
    input logic [7:0] ptr_addr,
    input logic       cfg_normal,
    input logic       cfg_mode16,
    input logic [2:0] cfg_scan_per
);
    AST_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> cfg_normal);  // R12
    AST_WR_IN_DISP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ptr_addr[7:4] == 4'h0);  // R8
    AST_WRAP_TWENTY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cfg_mode16 && ptr_addr == 8'h09) |=> ptr_addr == 8'h00);  // R8
    AST_WRAP_SIXTEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cfg_mode16 && ptr_addr == 8'h0F) |=> ptr_addr == 8'h00);  // R9
    AST_SCAN_HELD_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_normal |=> $stable(cfg_scan_per));  // R12
    AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_f);  // R1
    AST_PTR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_addr[7:4] == 4'h0 || (ptr_addr >= 8'h20 && ptr_addr <= 8'h22) || ptr_addr == 8'h30);  // R11
endmodule

bind i2c_cmd_regif i2cr_checks u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_f       (scl_f),
    .sda_pull    (sda_pull),
    .wr_en       (wr_en),
    .ptr_addr    (ptr_addr),
    .cfg_normal  (cfg_normal),
    .cfg_mode16  (cfg_mode16),
    .cfg_scan_per(cfg_scan_per)
);

// File: tb/sim_i2c_cmd_regif.sv
module sim_i2c_cmd_regif;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_bus;
    logic sda_pull, wr_en, key_rd;
    logic [7:0] ptr_addr, rd_data, wr_data;
    logic cfg_normal, cfg_disp_on, cfg_mode16, cfg_int_pin, cfg_int_high;
    logic [2:0] cfg_scan_per;

    int n_chk = 0;
    int n_bad = 0;
    int wr_cnt = 0;
    int key_cnt = 0;
    bit done = 0;
    logic [7:0] disp_mem [16];
    logic [7:0] model;

    always #2 clk = ~clk;

    assign sda_bus = m_sda & ~sda_pull;

    i2c_cmd_regif u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
        .sda_pull(sda_pull), .ptr_addr(ptr_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_data(wr_data), .key_rd(key_rd),
        .cfg_normal(cfg_normal), .cfg_disp_on(cfg_disp_on), .cfg_mode16(cfg_mode16),
        .cfg_int_pin(cfg_int_pin), .cfg_int_high(cfg_int_high), .cfg_scan_per(cfg_scan_per)
    );

    always_comb begin
        case (ptr_addr)
            8'h20:   rd_data = 8'hA5;
            8'h21:   rd_data = 8'h3C;
            8'h22:   rd_data = 8'h0F;
            8'h30:   rd_data = 8'h01;
            default: rd_data = (ptr_addr[7:4] == 4'h0) ? disp_mem[ptr_addr[3:0]] : 8'h00;
        endcase
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) disp_mem[i] <= 8'h00;
        end else begin
            if (wr_en) begin
                disp_mem[ptr_addr[3:0]] <= wr_data;
                wr_cnt <= wr_cnt + 1;
            end
            if (key_rd) key_cnt <= key_cnt + 1;
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(2 * Q);
        m_sda = 1'b0; wq(2 * Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b1; wq(2 * Q);
        m_sda = 1'b1; wq(2 * Q);
    endtask

    task automatic bit_out(input logic v);
        m_sda = v;    wq(Q);
        m_scl = 1'b1; wq(2 * Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bit_in(output logic v);
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        v = sda_bus;  wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic nak);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(nak);
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] b);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            bit_in(v);
            b[i] = v;
        end
        bit_out(~ack);
    endtask

    task automatic send_cmd(input logic [7:0] b);
        logic nak;
        i2c_start();
        send_byte(8'hE6, nak);
        send_byte(b, nak);
        i2c_stop();
    endtask

    function automatic logic [7:0] cfg_now();
        return {cfg_normal, cfg_disp_on, cfg_mode16, cfg_int_pin, cfg_int_high, cfg_scan_per};
    endfunction

    task automatic model_apply(input logic [7:0] b);
        if ((b & 8'hF9) == 8'h80) begin
            model[7] = b[1];
            model[6] = b[2];
        end else if (model[7]) begin
            if ((b & 8'hF8) == 8'hA0) begin
                model[5] = b[0];
                model[4] = b[1];
                model[3] = b[2];
            end else if ((b & 8'hF8) == 8'hF8) begin
                model[2:0] = b[2:0];
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic nak;
        logic [7:0] rb;
        logic [7:0] p0;
        int w0, k0;
        string tag;

        wq(5);
        rst_n = 1'b1;
        wq(5);

        // R2: reset state
        chk("R2 cfg", cfg_now(), 8'h00);
        chk("R2 ptr", ptr_addr, 8'h00);
        chk("R2 pull", sda_pull, 1'b0);
        model = 8'h00;

        // R1: foreign address is not acknowledged and changes nothing
        i2c_start();
        send_byte(8'hA0, nak);
        chk("R1 foreign nak", nak, 1'b1);
        send_byte(8'h86, nak);
        i2c_stop();
        chk("R1 foreign cfg", cfg_now(), 8'h00);
        i2c_start();
        send_byte(8'hE6, nak);
        chk("R1 own ack", nak, 1'b0);
        i2c_stop();

        // R3 R4 R5 R6 R12: sweep of the whole command half of the byte space
        for (int b = 8'h80; b <= 8'hFF; b++) begin
            if ((b & 8'hF9) == 8'h80)      tag = "R3 sys";
            else if (!model[7])            tag = "R12 gate";
            else if ((b & 8'hF8) == 8'hA0) tag = "R4 mode";
            else if ((b & 8'hF8) == 8'hF8) tag = "R5 scan";
            else                           tag = "R6 undef";
            send_cmd(8'(b));
            model_apply(8'(b));
            chk(tag, cfg_now(), model);
        end

        // R12: standby blocks mode set, pointer set and writes
        send_cmd(8'h80);
        model_apply(8'h80);
        chk("R12 standby", cfg_now(), model);
        p0 = ptr_addr;
        send_cmd(8'hA0);
        chk("R12 mode blocked", cfg_now(), model);
        w0 = wr_cnt;
        i2c_start();
        send_byte(8'hE6, nak);
        send_byte(8'h03, nak);
        send_byte(8'h11, nak);
        i2c_stop();
        chk("R12 no write", wr_cnt, w0);
        chk("R12 ptr held", ptr_addr, p0);
        send_cmd(8'h82);
        model_apply(8'h82);
        chk("R3 wake", cfg_now(), model);

        // R7: byte after a command is ignored
        w0 = wr_cnt;
        i2c_start();
        send_byte(8'hE6, nak);
        send_byte(8'hA0, nak);
        send_byte(8'h05, nak);
        chk("R7 ack", nak, 1'b0);
        i2c_stop();
        model_apply(8'hA0);
        chk("R7 cfg", cfg_now(), model);
        chk("R7 no write", wr_cnt, w0);

        // R8: page write in 20x4 mode wraps after 0x09
        w0 = wr_cnt;
        i2c_start();
        send_byte(8'hE6, nak);
        send_byte(8'h08, nak);
        send_byte(8'h11, nak);
        send_byte(8'h22, nak);
        send_byte(8'h33, nak);
        i2c_stop();
        chk("R8 count", wr_cnt, w0 + 3);
        chk("R8 at 08", disp_mem[8], 8'h11);
        chk("R8 at 09", disp_mem[9], 8'h22);
        chk("R8 wrap 00", disp_mem[0], 8'h33);
        chk("R8 0A untouched", disp_mem[10], 8'h00);
        chk("R8 ptr", ptr_addr, 8'h01);

        // R9: page write in 16x8 mode wraps after 0x0F
        send_cmd(8'hA1);
        i2c_start();
        send_byte(8'hE6, nak);
        send_byte(8'h0E, nak);
        send_byte(8'h44, nak);
        send_byte(8'h55, nak);
        send_byte(8'h66, nak);
        i2c_stop();
        chk("R9 at 0E", disp_mem[14], 8'h44);
        chk("R9 at 0F", disp_mem[15], 8'h55);
        chk("R9 wrap 00", disp_mem[0], 8'h66);

        // R10 R13 R14: pointer set, repeated start, read with wrap, NACK
        i2c_start();
        send_byte(8'hE6, nak);
        send_byte(8'h0E, nak);
        i2c_start();
        send_byte(8'hE7, nak);
        chk("R13 read ack", nak, 1'b0);
        recv_byte(1'b1, rb);
        chk("R10 byte 0E", rb, 8'h44);
        recv_byte(1'b1, rb);
        chk("R10 byte 0F", rb, 8'h55);
        recv_byte(1'b0, rb);
        chk("R10 wrap 00", rb, 8'h66);
        wq(2);
        chk("R14 released", sda_pull, 1'b0);
        chk("R14 ptr kept", ptr_addr, 8'h00);
        i2c_stop();

        // R11: key reads wrap 0x22 to 0x20 and pulse the strobe
        k0 = key_cnt;
        i2c_start();
        send_byte(8'hE6, nak);
        send_byte(8'h21, nak);
        i2c_start();
        send_byte(8'hE7, nak);
        recv_byte(1'b1, rb);
        chk("R11 key 21", rb, 8'h3C);
        recv_byte(1'b1, rb);
        chk("R11 key 22", rb, 8'h0F);
        recv_byte(1'b1, rb);
        chk("R11 key wrap 20", rb, 8'hA5);
        recv_byte(1'b0, rb);
        chk("R11 key 21 again", rb, 8'h3C);
        i2c_stop();
        chk("R11 strobes", key_cnt, k0 + 4);
        chk("R11 key ptr", ptr_addr, 8'h21);

        // R11: flag pointer does not advance
        i2c_start();
        send_byte(8'hE6, nak);
        send_byte(8'h30, nak);
        i2c_start();
        send_byte(8'hE7, nak);
        recv_byte(1'b1, rb);
        chk("R11 flag", rb, 8'h01);
        recv_byte(1'b0, rb);
        chk("R11 flag again", rb, 8'h01);
        i2c_stop();
        chk("R11 flag ptr", ptr_addr, 8'h30);

        // R6: undefined key pointer form leaves the pointer alone
        send_cmd(8'h23);
        chk("R6 ptr", ptr_addr, 8'h30);

        // R13: repeated start in the middle of a write
        i2c_start();
        send_byte(8'hE6, nak);
        send_byte(8'h02, nak);
        send_byte(8'h77, nak);
        i2c_start();
        send_byte(8'hE6, nak);
        send_byte(8'h05, nak);
        send_byte(8'h88, nak);
        i2c_stop();
        chk("R13 first", disp_mem[2], 8'h77);
        chk("R13 second", disp_mem[5], 8'h88);
        chk("R13 no stray", disp_mem[3], 8'h00);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule